// File: doc/BRIEF.md
# Load/Store Byte-Lane Aligner

This block sits between a 32-bit processor pipeline and a word-organised data memory. For every access it adds a 16-bit offset to a base register to form the byte address, and hands the memory the word address. For stores, it steers the low bits of the source register onto the right byte lanes and raises the matching byte enables. For loads, it picks the addressed byte or halfword out of the returned word and widens it to 32 bits. The widening either copies the sign bit upward or fills with zeros.

The two kinds of access treat the offset differently. A load offset is a signed quantity, so it is sign-extended before the add. A store offset is an unsigned 16-bit field, so it is zero-extended. Lanes are numbered big-endian: address offset 0 within a word is bits 31:24.

The memory answers a read in the same cycle that the aligner presents the address. The aligner registers the word together with the size, low address bits and signedness of that request. One cycle later it presents the widened result. An access whose address is not a multiple of its size raises an error and does not reach the memory.

Top module: `lsu_lane_aligner`

## Requirements
- R1: With no request (`req_valid` low), `mem_we`, `mem_re`, `misalign` and all of `mem_be` are 0. `load_valid` is 0 after reset.
- R2: For a load, `mem_word_addr` equals bits 31:2 of `base` plus `offset` sign-extended to 32 bits, and `mem_re` is 1 in the request cycle.
- R3: For a store, `mem_word_addr` equals bits 31:2 of `base` plus `offset` zero-extended to 32 bits.
- R4: Size code 2'b00 selects a byte. A byte store at address low bits k sets only `mem_be` bit 3-k, where bit 3 covers data bits 31:24. The low 8 bits of `store_data` appear in all four lanes of `mem_wdata`.
- R5: Size code 2'b01 selects a halfword. An aligned halfword store sets `mem_be` to 4'b1100 at offset 0 and to 4'b0011 at offset 2. The low 16 bits of `store_data` appear in both halves of `mem_wdata`.
- R6: Size codes 2'b10 and 2'b11 select a word. An aligned word store sets `mem_be` to 4'b1111 and `mem_wdata` equal to `store_data`.
- R7: A byte load returns the byte at lane offset k, which is `mem_rdata` bits 31-8k down to 24-8k. Bits 31:8 of the result copy bit 7 when `req_signed` is 1, and are zero when it is 0.
- R8: A halfword load returns `mem_rdata` bits 31:16 at offset 0 and bits 15:0 at offset 2. Bits 31:16 of the result copy bit 15 when signed, and are zero when unsigned.
- R9: A word load returns `mem_rdata` unchanged, whatever the value of `req_signed`.
- R10: A halfword with address bit 0 set, or a word with either of address bits 1:0 set, raises `misalign` in the request cycle. `mem_we`, `mem_re` and `mem_be` stay 0, and no `load_valid` follows.
- R11: `load_valid` and `load_data` appear exactly one cycle after an accepted load. They are computed from the size, address and signedness captured with that load, even when a new request is presented in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 1x word |
| req_signed | input | 1 | Load widening copies the sign bit when 1 |
| base | input | 32 | Base register value |
| offset | input | 16 | Address offset field |
| store_data | input | 32 | Store source register |
| mem_rdata | input | 32 | Memory read word, valid in the request cycle |
| mem_word_addr | output | 30 | Word address to memory |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_be | output | 4 | Byte enables, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Lane-steered write data |
| misalign | output | 1 | Misaligned access error |
| load_valid | output | 1 | Widened load result valid |
| load_data | output | 32 | Widened load result |

## Verification
The aligner delivers the result of the previous load in the same cycle that it decodes a new request. The two functions share no control state, so the bench issues a fresh random request on every cycle. Loads are followed at once by stores, by misaligned accesses and by loads of a different size and signedness. The bench computes the expected widened value from the request it remembers from the previous cycle, not from the current inputs. It compares that value and `load_valid` while the new request's strobes, enables and lane data are checked against their own expectations.

// File: rtl/lsu_lane_pkg.sv
// Package: shared types for the load/store lane aligner.
// Assumes access size is encoded in two bits; the top code behaves as a word.
package lsu_lane_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WIDE = 2'b11
    } acc_size_e;
endpackage

// File: rtl/lsu_ea_gen.sv
// Effective-address adder.
// Loads widen the offset as a signed value, stores as an unsigned field.
// Assumes OFF_W < ADDR_W.
module lsu_ea_gen #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [OFF_W-1:0]  offset,
    input  logic              is_store,
    output logic [ADDR_W-1:0] ea
);
    localparam int PAD_W = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] off_wide;

    // Pick the offset widening that matches the access direction.
    always_comb begin
        if (is_store) off_wide = {{PAD_W{1'b0}}, offset};
        else          off_wide = {{PAD_W{offset[OFF_W-1]}}, offset};
        ea = base + off_wide;
    end
endmodule

// File: rtl/lsu_store_lanes.sv
// Store lane steering.
// Produces per-lane byte enables and write data for byte, halfword and word
// stores with big-endian lane numbering (offset 0 = most significant lane).
// Assumes the caller has already qualified 'enable' with alignment.
module lsu_store_lanes
    import lsu_lane_pkg::*;
#(
    parameter  int DATA_W = 32,
    localparam int LANES  = DATA_W / 8,
    localparam int LO_W   = $clog2(LANES)
) (
    input  logic              enable,
    input  acc_size_e         size,
    input  logic [LO_W-1:0]   lo,
    input  logic [DATA_W-1:0] src,
    output logic [LANES-1:0]  be,
    output logic [DATA_W-1:0] lane_data
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam logic [LO_W-1:0] POS     = LO_W'(LANES - 1 - i);
        localparam bit              UPPER_H = (i % 2) == 1;

        logic       hit;
        logic [7:0] byte_out;

        // Decide whether this lane is written and which source byte it carries.
        always_comb begin
            unique case (size)
                SZ_BYTE: begin
                    hit      = (lo == POS);
                    byte_out = src[7:0];
                end
                SZ_HALF: begin
                    hit      = (lo[LO_W-1:1] == POS[LO_W-1:1]);
                    byte_out = UPPER_H ? src[15:8] : src[7:0];
                end
                default: begin
                    hit      = 1'b1;
                    byte_out = src[8*i +: 8];
                end
            endcase
        end

        assign be[i]             = enable & hit;
        assign lane_data[8*i +: 8] = byte_out;
    end
endmodule

// File: rtl/lsu_load_extend.sv
// Load capture and widening.
// Registers the memory word with the request's size, lane offset and
// signedness, then extracts and widens the addressed item in the next cycle.
// Assumes the memory returns the read word in the request cycle.
module lsu_load_extend
    import lsu_lane_pkg::*;
#(
    parameter  int DATA_W = 32,
    localparam int LANES  = DATA_W / 8,
    localparam int LO_W   = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  acc_size_e         size,
    input  logic [LO_W-1:0]   lo,
    input  logic              sgn,
    input  logic [DATA_W-1:0] word,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data
);
    logic              cap_valid;
    acc_size_e         cap_size;
    logic [LO_W-1:0]   cap_lo;
    logic              cap_sgn;
    logic [DATA_W-1:0] cap_word;
    logic [7:0]        byte_v;
    logic [15:0]       half_v;

    // Capture one accepted load; valid drops when no load was accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_valid <= 1'b0;
            cap_size  <= SZ_BYTE;
            cap_lo    <= '0;
            cap_sgn   <= 1'b0;
            cap_word  <= '0;
        end else begin
            cap_valid <= take;
            if (take) begin
                cap_size <= size;
                cap_lo   <= lo;
                cap_sgn  <= sgn;
                cap_word <= word;
            end
        end
    end

    // Pull out the addressed byte and halfword, big-endian lane order.
    always_comb begin
        int bidx;
        int hidx;
        bidx   = LANES - 1 - int'(cap_lo);
        hidx   = LANES / 2 - 1 - int'(cap_lo[LO_W-1:1]);
        byte_v = cap_word[bidx*8 +: 8];
        half_v = cap_word[hidx*16 +: 16];
    end

    // Widen the extracted item by sign copy or zero fill.
    always_comb begin
        unique case (cap_size)
            SZ_BYTE: res_data = {{(DATA_W-8){cap_sgn & byte_v[7]}}, byte_v};
            SZ_HALF: res_data = {{(DATA_W-16){cap_sgn & half_v[15]}}, half_v};
            default: res_data = cap_word;
        endcase
    end

    assign res_valid = cap_valid;

    AST_ZEXT_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(size) == SZ_BYTE && !$past(sgn) && $past(take))
            |-> res_data[DATA_W-1:8] == '0);  // R7
    AST_SEXT_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(size) == SZ_HALF && $past(sgn) && $past(take))
            |-> res_data[DATA_W-1:16] == {(DATA_W-16){res_data[15]}});  // R8
endmodule

// File: rtl/lsu_lane_aligner.sv
// Load/store byte-lane aligner (top).
// Forms the effective address, gates memory strobes on alignment, steers
// store lanes and widens load results one cycle after the request.
// Assumes a memory that reads combinationally and writes on the clock edge.
module lsu_lane_aligner
    import lsu_lane_pkg::*;
#(
    parameter  int ADDR_W = 32,
    parameter  int DATA_W = 32,
    parameter  int OFF_W  = 16,
    localparam int LANES  = DATA_W / 8,
    localparam int LO_W   = $clog2(LANES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic                   req_store,
    input  logic [1:0]             req_size,
    input  logic                   req_signed,
    input  logic [ADDR_W-1:0]      base,
    input  logic [OFF_W-1:0]       offset,
    input  logic [DATA_W-1:0]      store_data,
    input  logic [DATA_W-1:0]      mem_rdata,
    output logic [ADDR_W-LO_W-1:0] mem_word_addr,
    output logic                   mem_re,
    output logic                   mem_we,
    output logic [LANES-1:0]       mem_be,
    output logic [DATA_W-1:0]      mem_wdata,
    output logic                   misalign,
    output logic                   load_valid,
    output logic [DATA_W-1:0]      load_data
);
    acc_size_e         size_e;
    logic [ADDR_W-1:0] ea;
    logic [LO_W-1:0]   lo;
    logic              bad_align;
    logic              go;

    assign size_e = acc_size_e'(req_size);

    lsu_ea_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ea (
        .base     (base),
        .offset   (offset),
        .is_store (req_store),
        .ea       (ea)
    );

    assign lo            = ea[LO_W-1:0];
    assign mem_word_addr = ea[ADDR_W-1:LO_W];

    // Flag an address that is not a multiple of the access size.
    always_comb begin
        unique case (size_e)
            SZ_BYTE: bad_align = 1'b0;
            SZ_HALF: bad_align = lo[0];
            default: bad_align = (lo != '0);
        endcase
    end

    assign misalign = req_valid & bad_align;
    assign go       = req_valid & ~bad_align;
    assign mem_we   = go & req_store;
    assign mem_re   = go & ~req_store;

    lsu_store_lanes #(.DATA_W(DATA_W)) u_st (
        .enable    (mem_we),
        .size      (size_e),
        .lo        (lo),
        .src       (store_data),
        .be        (mem_be),
        .lane_data (mem_wdata)
    );

    lsu_load_extend #(.DATA_W(DATA_W)) u_ld (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (mem_re),
        .size      (size_e),
        .lo        (lo),
        .sgn       (req_signed),
        .word      (mem_rdata),
        .res_valid (load_valid),
        .res_data  (load_data)
    );

    AST_MISALIGN_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (!mem_we && !mem_re && mem_be == '0));  // R10
    AST_BE_POPULATION: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2
                    || $countones(mem_be) == LANES));  // R4
    AST_LOAD_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        load_valid |-> $past(mem_re));  // R11
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!mem_we && !mem_re && !misalign && mem_be == '0));  // R1
    AST_NO_STALE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req_valid) |-> !load_valid);  // R11
endmodule

// File: tb/tb_lsu_lane_aligner.sv
// Bench for the lane aligner: random requests every cycle plus directed
// corner cases; expectations come from bench functions.
module tb_lsu_lane_aligner;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_store = 1'b0;
    logic [1:0]  req_size = 2'b00;
    logic        req_signed = 1'b0;
    logic [31:0] base = '0;
    logic [15:0] offset = '0;
    logic [31:0] store_data = '0;
    logic [31:0] mem_rdata = '0;
    logic [29:0] mem_word_addr;
    logic        mem_re;
    logic        mem_we;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic        misalign;
    logic        load_valid;
    logic [31:0] load_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // previous-cycle request, remembered for load result checking
    bit          p_ld = 0;
    logic [1:0]  p_size = 0;
    logic        p_sgn = 0;
    logic [1:0]  p_lo = 0;
    logic [31:0] p_word = 0;

    always #2 clk = ~clk;

    lsu_lane_aligner dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
        .req_size(req_size), .req_signed(req_signed), .base(base), .offset(offset),
        .store_data(store_data), .mem_rdata(mem_rdata), .mem_word_addr(mem_word_addr),
        .mem_re(mem_re), .mem_we(mem_we), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .misalign(misalign), .load_valid(load_valid), .load_data(load_data)
    );

    function automatic logic [31:0] f_ea(logic [31:0] b, logic [15:0] o, logic st);
        return st ? b + {16'h0, o} : b + {{16{o[15]}}, o};
    endfunction

    function automatic logic f_mis(logic [1:0] sz, logic [1:0] lo);
        if (sz == 2'b00) return 1'b0;
        if (sz == 2'b01) return lo[0];
        return lo != 2'b00;
    endfunction

    function automatic logic [3:0] f_be(logic [1:0] sz, logic [1:0] lo);
        if (sz == 2'b00) return 4'b1000 >> lo;
        if (sz == 2'b01) return lo[1] ? 4'b0011 : 4'b1100;
        return 4'b1111;
    endfunction

    function automatic logic [31:0] f_wdata(logic [1:0] sz, logic [31:0] d);
        if (sz == 2'b00) return {4{d[7:0]}};
        if (sz == 2'b01) return {2{d[15:0]}};
        return d;
    endfunction

    function automatic logic [31:0] f_load(logic [31:0] w, logic [1:0] sz,
                                           logic [1:0] lo, logic sg);
        logic [7:0]  b;
        logic [15:0] h;
        case (lo)
            2'd0: b = w[31:24];
            2'd1: b = w[23:16];
            2'd2: b = w[15:8];
            default: b = w[7:0];
        endcase
        h = lo[1] ? w[15:0] : w[31:16];
        if (sz == 2'b00) return {{24{sg & b[7]}}, b};
        if (sz == 2'b01) return {{16{sg & h[15]}}, h};
        return w;
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
        end
    endtask

    // Apply one request at the falling edge, then check this cycle's outputs
    // and the result of the previous cycle's load.
    task automatic step(logic v, logic st, logic [1:0] sz, logic sg,
                        logic [31:0] b, logic [15:0] o, logic [31:0] sd,
                        logic [31:0] rd);
        logic [31:0] ea;
        logic        mis;
        string       ltag;
        @(negedge clk);
        req_valid = v; req_store = st; req_size = sz; req_signed = sg;
        base = b; offset = o; store_data = sd; mem_rdata = rd;
        #1;
        ea  = f_ea(b, o, st);
        mis = v && f_mis(sz, ea[1:0]);
        // R11: result of the previous load, unaffected by the new request
        chk("R11 load_valid", {31'h0, load_valid}, {31'h0, p_ld});
        if (p_ld) begin
            ltag = (p_size == 2'b00) ? "R7 byte load" :
                   (p_size == 2'b01) ? "R8 half load" : "R9 word load";
            chk(ltag, load_data, f_load(p_word, p_size, p_lo, p_sgn));
        end
        chk(v ? "R10 misalign" : "R1 idle misalign", {31'h0, misalign}, {31'h0, mis});
        chk("R10 mem_we", {31'h0, mem_we}, {31'h0, v && st && !mis});
        chk("R10 mem_re", {31'h0, mem_re}, {31'h0, v && !st && !mis});
        if (v && st && !mis) begin
            chk(sz == 2'b00 ? "R4 be" : sz == 2'b01 ? "R5 be" : "R6 be",
                {28'h0, mem_be}, {28'h0, f_be(sz, ea[1:0])});
            chk(sz == 2'b00 ? "R4 wdata" : sz == 2'b01 ? "R5 wdata" : "R6 wdata",
                mem_wdata, f_wdata(sz, sd));
            chk("R3 store addr", {2'b0, mem_word_addr}, {2'b0, ea[31:2]});
        end else begin
            chk("R1 be quiet", {28'h0, mem_be}, 32'h0);
        end
        if (v && !st && !mis)
            chk("R2 load addr", {2'b0, mem_word_addr}, {2'b0, ea[31:2]});
        p_ld = v && !st && !mis;
        p_size = sz; p_sgn = sg; p_lo = ea[1:0]; p_word = rd;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 reset load_valid", {31'h0, load_valid}, 32'h0);
        chk("R1 reset mem_we", {31'h0, mem_we}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 post-reset load_valid", {31'h0, load_valid}, 32'h0);

        // R2/R3: negative offset widened differently for load and store
        step(1, 0, 2'b10, 0, 32'h0001_0000, 16'h8000, 0, 32'hCAFE_F00D);
        step(1, 1, 2'b10, 0, 32'h0001_0000, 16'h8000, 32'h1234_5678, 0);
        // R7: every byte lane, signed then unsigned, negative byte values
        for (int k = 0; k < 4; k++) begin
            step(1, 0, 2'b00, 1, 32'h100 + k, 16'h0, 0, 32'h80C3_F17E);
            step(1, 0, 2'b00, 0, 32'h100 + k, 16'h0, 0, 32'h80C3_F17E);
        end
        // R4: byte stores at each lane
        for (int k = 0; k < 4; k++)
            step(1, 1, 2'b00, 0, 32'h200, 16'(k), 32'hAABB_CCDD, 0);
        // R8/R5: halfwords at both offsets
        step(1, 0, 2'b01, 1, 32'h300, 16'h0, 0, 32'h8001_7FFE);
        step(1, 0, 2'b01, 1, 32'h302, 16'h0, 0, 32'h8001_F00E);
        step(1, 0, 2'b01, 0, 32'h302, 16'h0, 0, 32'h8001_F00E);
        step(1, 1, 2'b01, 0, 32'h300, 16'h2, 32'h0000_BEEF, 0);
        // R9: word load with signed flag set stays unchanged; code 11 is a word
        step(1, 0, 2'b10, 1, 32'h400, 16'h0, 0, 32'hFFFF_0001);
        step(1, 0, 2'b11, 0, 32'h404, 16'h0, 0, 32'h8000_0000);
        step(1, 1, 2'b11, 0, 32'h404, 16'h4, 32'h0BAD_CAFE, 0);
        // R10: misaligned half and word, load and store
        step(1, 0, 2'b01, 1, 32'h501, 16'h0, 0, 32'hFFFF_FFFF);
        step(1, 1, 2'b10, 0, 32'h500, 16'h2, 32'hFFFF_FFFF, 0);
        step(1, 0, 2'b10, 0, 32'h503, 16'h0, 0, 32'h1111_2222);
        step(0, 0, 2'b00, 0, 0, 0, 0, 0);
        // R11: load immediately followed by a store and by a different load
        step(1, 0, 2'b00, 1, 32'h600, 16'h1, 0, 32'h00F0_0000);
        step(1, 1, 2'b10, 0, 32'h600, 16'h0, 32'h5555_AAAA, 32'hFFFF_FFFF);
        step(1, 0, 2'b01, 0, 32'h602, 16'h0, 0, 32'h0000_8123);
        step(1, 0, 2'b00, 1, 32'h603, 16'h0, 0, 32'h0000_0080);

        // constrained random: any request every cycle
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[3:0] != 0, r[4], r[6:5], r[7], $urandom, 16'($urandom),
                 $urandom, $urandom);
        end
        step(0, 0, 2'b00, 0, 0, 0, 0, 0);
        step(0, 0, 2'b00, 0, 0, 0, 0, 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule